// File: doc/BRIEF.md
# Deep-Sleep Wake Detector

This block keeps watch over a bank of level-sensitive interrupt lines and a debug halt line while the processor core sits in deep sleep with its clocks stopped or its logic power-gated. It runs on an always-on clock. It has no registers that software can program. When the core enters sleep, its interrupt controller presents the current interrupt enable mask together with a one-cycle load strobe and a flag that says whether deep sleep was selected. The block captures that mask and arms itself only when deep sleep was selected. After a normal-sleep entry it stays idle, and the core's own logic keeps the job of detecting wake events.

While armed, an interrupt line that is high and enabled in the captured mask raises a request to the power management unit. A debug halt request raises the same request whatever the mask holds. The request stays high until the power management unit acknowledges that power and clocks are back. The block then returns to idle and clears its mask. The core's periodic tick timer is stopped in this mode, so a timed wake has to arrive on one of the external interrupt lines, for example from a peripheral timer.

Top module: `wake_detect`

## Requirements
- R1: After reset, and whenever reset is asserted, `armed` and `pmu_req` are both low.
- R2: A `mask_load` pulse with `deep_sel` high, taken in idle with no enabled line high and no debug halt, drives `armed` high on the next cycle and stores `mask_in` as the mask. Bit i of the mask enables line i, and 1 means enabled.
- R3: A `mask_load` pulse with `deep_sel` low does not arm the block. Interrupt lines that are high while the block is idle never raise `pmu_req`.
- R4: While armed, any `irq_lvl` bit that is high and enabled in the stored mask drives `pmu_req` high and `armed` low on the next cycle.
- R5: While armed, interrupt lines whose mask bit is 0 have no effect. `armed` stays high and `pmu_req` stays low.
- R6: If an enabled line (judged against `mask_in`) or `dbg_halt` is already high in the cycle of the arming `mask_load`, `pmu_req` goes high on the next cycle and `armed` never goes high.
- R7: While armed, `dbg_halt` high drives `pmu_req` high on the next cycle, even when the mask is all zeros.
- R8: Once high, `pmu_req` stays high until `pmu_ack` is seen, even if the line that caused it falls.
- R9: `pmu_ack` seen while `pmu_req` is high returns the block to idle on the next cycle. Later interrupt lines have no effect until the next arming load.
- R10: A `mask_load` pulse while armed is ignored, and the stored mask keeps its earlier value.
- R11: `pmu_ack` seen while armed and no wake is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lvl | input | NUM_IRQ | Level-sensitive interrupt lines |
| dbg_halt | input | 1 | Debug halt request |
| mask_load | input | 1 | One-cycle strobe from the interrupt controller at sleep entry |
| deep_sel | input | 1 | Deep sleep selected for this sleep entry |
| mask_in | input | NUM_IRQ | Interrupt enable mask handed over at sleep entry |
| pmu_req | output | 1 | Wake request to the power management unit |
| pmu_ack | input | 1 | Power management unit reports that power and clocks are restored |
| armed | output | 1 | Detector is armed and watching |

## Verification
The stored mask cannot be read at the ports. It shows only through which lines later raise a wake. The hardest case to reach is a second load strobe that arrives while the block is armed and must be ignored. The stimulus arms the block with one mask, pulses a load with a different mask, and then raises first the line that only the ignored mask enables and then the line the original mask enables. A wake on the second line and none on the first shows that the original mask was kept. A line that is already high at the moment of arming is also driven in the same cycle as the load strobe, to catch a design that arms first and wakes one cycle late.

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lvl,
  input  logic               dbg_halt,
  input  logic               mask_load,
  input  logic               deep_sel,
  input  logic [NUM_IRQ-1:0] mask_in,
  output logic               pmu_req,
  input  logic               pmu_ack,
  output logic               armed
);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_WAKE} st_t;

  st_t                st, st_nx;
  logic [NUM_IRQ-1:0] mask_q, mask_nx;

  wire hit_held = |(irq_lvl & mask_q);
  wire hit_load = |(irq_lvl & mask_in);
  wire arm_go   = mask_load && deep_sel;

  always_comb begin
    st_nx   = st;
    mask_nx = mask_q;
    case (st)
      S_IDLE: begin
        if (arm_go) begin
          mask_nx = mask_in;
          st_nx   = (hit_load || dbg_halt) ? S_WAKE : S_ARMED;
        end
      end
      S_ARMED: begin
        if (hit_held || dbg_halt) st_nx = S_WAKE;
      end
      S_WAKE: begin
        if (pmu_ack) begin
          st_nx   = S_IDLE;
          mask_nx = '0;
        end
      end
      default: begin
        st_nx   = S_IDLE;
        mask_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mask_q <= '0;
    end else begin
      st     <= st_nx;
      mask_q <= mask_nx;
    end
  end

  assign armed   = (st == S_ARMED);
  assign pmu_req = (st == S_WAKE);

endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_lvl,
  input logic               dbg_halt,
  input logic               mask_load,
  input logic               deep_sel,
  input logic               pmu_req,
  input logic               pmu_ack,
  input logic               armed,
  input logic [NUM_IRQ-1:0] mask_q
);

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && pmu_req));

  a_r3_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !pmu_req && !(mask_load && deep_sel)) |=> (!armed && !pmu_req));

  a_r4_wake_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (|(irq_lvl & mask_q))) |=> pmu_req);

  a_r7_dbg_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dbg_halt) |=> pmu_req);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pmu_req && !pmu_ack) |=> pmu_req);

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pmu_req && pmu_ack) |=> (!pmu_req && !armed));

  a_r11_hold_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !dbg_halt && !(|(irq_lvl & mask_q))) |=> (armed && !pmu_req));

  a_r10_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(mask_q));

endmodule

bind wake_detect wake_detect_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .dbg_halt(dbg_halt),
  .mask_load(mask_load), .deep_sel(deep_sel), .pmu_req(pmu_req),
  .pmu_ack(pmu_ack), .armed(armed), .mask_q(mask_q)
);

// File: tb/tb_wake_detect.sv
`timescale 1ns/1ps
module tb_wake_detect;
  localparam int N = 8;
  localparam int NV = 19;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_lvl = '0;
  logic         dbg_halt = 1'b0;
  logic         mask_load = 1'b0;
  logic         deep_sel = 1'b0;
  logic [N-1:0] mask_in = '0;
  logic         pmu_ack = 1'b0;
  logic         pmu_req, armed;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_detect #(.NUM_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .dbg_halt(dbg_halt),
    .mask_load(mask_load), .deep_sel(deep_sel), .mask_in(mask_in),
    .pmu_req(pmu_req), .pmu_ack(pmu_ack), .armed(armed)
  );

  // fields: load, deep, mask_in, irq, dbg, ack, exp_armed, exp_req
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0}, // R1 idle
    {1'b1,1'b0,8'hFF,8'h00,1'b0,1'b0,1'b0,1'b0}, // R3 normal sleep load
    {1'b0,1'b0,8'h00,8'hFF,1'b0,1'b0,1'b0,1'b0}, // R3 irq while idle
    {1'b1,1'b1,8'h01,8'h00,1'b0,1'b0,1'b1,1'b0}, // R2 arm
    {1'b0,1'b0,8'h00,8'h02,1'b0,1'b0,1'b1,1'b0}, // R5 masked line
    {1'b0,1'b0,8'h00,8'h02,1'b0,1'b1,1'b1,1'b0}, // R11 stray ack
    {1'b1,1'b1,8'h02,8'h00,1'b0,1'b0,1'b1,1'b0}, // R10 load while armed
    {1'b0,1'b0,8'h00,8'h02,1'b0,1'b0,1'b1,1'b0}, // R10 new mask not taken
    {1'b0,1'b0,8'h00,8'h01,1'b0,1'b0,1'b0,1'b1}, // R4 wake
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1}, // R8 hold
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b0}, // R9 ack
    {1'b0,1'b0,8'h00,8'h01,1'b0,1'b0,1'b0,1'b0}, // R9 after release
    {1'b1,1'b1,8'h80,8'h80,1'b0,1'b0,1'b0,1'b1}, // R6 pending at arm
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b0}, // R9 ack
    {1'b1,1'b1,8'h00,8'h00,1'b0,1'b0,1'b1,1'b0}, // R2 empty mask
    {1'b0,1'b0,8'h00,8'hFF,1'b0,1'b0,1'b1,1'b0}, // R5 all masked
    {1'b0,1'b0,8'h00,8'hFF,1'b1,1'b0,1'b0,1'b1}, // R7 debug wake
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1}, // R8 hold
    {1'b0,1'b0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b0}  // R9 ack
  };
  localparam int VREQ [NV] = '{1,3,3,2,5,11,10,10,4,8,9,9,6,9,2,5,7,8,9};

  task automatic check(input string tag, input logic ea, input logic er);
    total++;
    if (armed !== ea || pmu_req !== er) begin
      bad++;
      $display("FAIL %s: armed=%b pmu_req=%b expected armed=%b pmu_req=%b",
               tag, armed, pmu_req, ea, er);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mask_load = VEC[i][21];
      deep_sel  = VEC[i][20];
      mask_in   = VEC[i][19:12];
      irq_lvl   = VEC[i][11:4];
      dbg_halt  = VEC[i][3];
      pmu_ack   = VEC[i][2];
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VREQ[i], i), VEC[i][1], VEC[i][0]);
      mask_load = 1'b0; deep_sel = 1'b0; mask_in = '0;
      irq_lvl = '0; dbg_halt = 1'b0; pmu_ack = 1'b0;
    end

    // R6: debug halt present at arming load
    @(negedge clk);
    mask_load = 1'b1; deep_sel = 1'b1; mask_in = 8'h00; dbg_halt = 1'b1;
    @(negedge clk);
    mask_load = 1'b0; deep_sel = 1'b0; dbg_halt = 1'b0;
    check("R6 debug at arm", 1'b0, 1'b1);

    // R8: request holds over several cycles without ack
    repeat (5) @(negedge clk);
    check("R8 long hold", 1'b0, 1'b1);

    // R1: reset asserted while request is high
    rst_n = 1'b0;
    #1;
    check("R1 reset during wake", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: highest line wakes, ack released with line still high
    @(negedge clk);
    mask_load = 1'b1; deep_sel = 1'b1; mask_in = 8'h81;
    @(negedge clk);
    mask_load = 1'b0; deep_sel = 1'b0;
    check("R2 rearm", 1'b1, 1'b0);
    irq_lvl = 8'h80;
    @(negedge clk);
    check("R4 top line", 1'b0, 1'b1);
    pmu_ack = 1'b1;
    @(negedge clk);
    pmu_ack = 1'b0;
    check("R9 release with line high", 1'b0, 1'b0);
    @(negedge clk);
    check("R9 no rewake", 1'b0, 1'b0);
    irq_lvl = '0;

    finish_run();
  end

  initial begin
    repeat (2000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected end before 2000 cycles");
    finish_run();
  end
endmodule